// File: doc/BRIEF.md
# Low-Power Sleep Sequencer

This block steps a device into and out of a low-power sleep state under control of one external request line. When the request goes high, the sequencer waits a short fixed entry delay and then turns off every input buffer, releases every output and bidirectional pin to high impedance, and removes the core enable. When the request goes low again, it waits a much longer wake-up delay before it brings the core and pads back. Registers inside the core lose their contents during sleep, so on the cycle the device becomes live again the sequencer raises a one-cycle re-initialise pulse.

Both delays are given in nanoseconds and turned into cycle counts of a free-running reference clock from the clock frequency parameter. The defaults are an 800 ns entry delay and a 200 us wake-up delay. A power-good input keeps all pads released and the core off until the supplies are valid, and it forces the same safe state whenever the supplies drop. The request and power-good inputs are expected to be synchronous to the reference clock.

Top module: `lp_sleep_seq`

## Requirements
- R1: While `rst_n` is low, `core_en`, every bit of `in_en` and `out_en`, and `reinit` are 0.
- R2: On the first clock edge at which `pwr_good` is sampled 1 after the off state, the block goes live: `core_en`, `in_en` and `out_en` become all ones and `reinit` is 1 for that cycle.
- R3: With `lp_req` held at 1 from the edge where it is first sampled high, the block stays live through ENTRY_CYC-1 further edges and goes to sleep at the ENTRY_CYC-th further edge, ENTRY_CYC being the entry delay in ns times the clock rate, rounded up.
- R4: While asleep, waking up, or powered off, `core_en` is 0 and every bit of `in_en` and `out_en` is 0 (pads released, input buffers off).
- R5: If `lp_req` returns to 0 before the entry delay runs out, the block stays live, issues no `reinit`, and a later request waits the full entry delay again.
- R6: With `lp_req` held at 0 from the edge where it is first sampled low during sleep, the block stays asleep through EXIT_CYC-1 further edges and goes live at the EXIT_CYC-th further edge, EXIT_CYC computed from the wake-up delay like ENTRY_CYC.
- R7: When wake-up completes, `reinit` is 1 for exactly one cycle, in the same cycle that `core_en` first returns to 1.
- R8: If `lp_req` goes back to 1 during the wake-up delay, the block returns to sleep without going live or pulsing `reinit`, and the next wake-up waits the full wake-up delay.
- R9: When `pwr_good` is sampled 0, the next cycle has `core_en`, `in_en`, `out_en` and `reinit` all 0, from any state.
- R10: While live, `lp_req` held at 0 has no effect: the enables stay all ones and `reinit` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_req | input | 1 | Sleep request; 1 asks for sleep, 0 asks for normal operation |
| pwr_good | input | 1 | 1 when the supplies are within operating range |
| core_en | output | 1 | 1 when the core is powered and running |
| in_en | output | IO_W | Per-pin input buffer enable, 1 = buffer on |
| out_en | output | IO_W | Per-pin output driver enable, 0 = high impedance |
| reinit | output | 1 | One-cycle pulse requesting re-initialisation of core state |

## Verification
The checker watches on every cycle that `reinit` is a single-cycle pulse that only occurs with the core live, that every rise of `core_en` is accompanied by `reinit`, that a power failure leaves everything off one cycle later, and that no sleep entry happens unless the request was seen high for longer than the entry delay. The exact entry and wake-up cycle counts, the aborted entry, the request reasserted during wake-up and the full reload of each delay after an interruption can only be shown by the bench's timed scenarios and its cycle model under random request patterns.

// File: rtl/lp_seq_pkg.sv
// Shared types and helpers for the low-power sleep sequencer.
// Assumes clock frequency in kHz and delays in ns, both positive.
package lp_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_RUN   = 3'd1,
        ST_ENTER = 3'd2,
        ST_SLEEP = 3'd3,
        ST_WAKE  = 3'd4
    } lp_state_e;

    // Convert a delay in ns into reference-clock cycles, rounding up, at least 1.
    function automatic int ns_to_cycles(input longint clk_khz, input longint ns);
        longint c;
        c = (clk_khz * ns + 64'd999_999) / 64'd1_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/lp_delay_cnt.sv
// Loadable down counter used for both the entry and the wake-up delay.
// Assumes load has priority over decrement; counter stops at zero.
module lp_delay_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             cnt_zero
);

    logic [CNT_W-1:0] cnt_q;

    // Hold, reload or count down the remaining delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/lp_seq_fsm.sv
// Sleep sequencing state machine. Power failure overrides every state;
// a request change during a delay aborts it; re-initialise is registered.
// Assumes lp_req and pwr_good are synchronous to clk.
module lp_seq_fsm
    import lp_seq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int ENTRY_LOAD = 0,
    parameter int EXIT_LOAD  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lp_req,
    input  logic             pwr_good,
    input  logic             cnt_zero,
    output lp_state_e        state,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             cnt_dec,
    output logic             reinit
);

    lp_state_e st_q, st_d;
    logic      live_now;

    // Next-state and counter-control decode.
    always_comb begin
        st_d     = st_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        live_now = 1'b0;
        if (!pwr_good) begin
            st_d = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF: begin
                    st_d     = ST_RUN;
                    live_now = 1'b1;
                end
                ST_RUN: begin
                    if (lp_req) begin
                        st_d     = ST_ENTER;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(ENTRY_LOAD);
                    end
                end
                ST_ENTER: begin
                    if (!lp_req)      st_d = ST_RUN;
                    else if (cnt_zero) st_d = ST_SLEEP;
                    else               cnt_dec = 1'b1;
                end
                ST_SLEEP: begin
                    if (!lp_req) begin
                        st_d     = ST_WAKE;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(EXIT_LOAD);
                    end
                end
                ST_WAKE: begin
                    if (lp_req) begin
                        st_d = ST_SLEEP;
                    end else if (cnt_zero) begin
                        st_d     = ST_RUN;
                        live_now = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                default: st_d = ST_OFF;
            endcase
        end
    end

    // State register and one-cycle re-initialise pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_OFF;
            reinit <= 1'b0;
        end else begin
            st_q   <= st_d;
            reinit <= live_now;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/lp_io_ctrl.sv
// Decodes the sequencer state into per-pin buffer enables and core enable.
// Pads and core are on only in the running and entry-pending states.
module lp_io_ctrl
    import lp_seq_pkg::*;
#(
    parameter int IO_W = 8
) (
    input  lp_state_e         state,
    output logic              core_en,
    output logic [IO_W-1:0]   in_en,
    output logic [IO_W-1:0]   out_en
);

    logic live;

    // Live when running or still counting down the entry delay.
    always_comb begin
        live = (state == ST_RUN) || (state == ST_ENTER);
    end

    assign core_en = live;

    genvar i;
    generate
        for (i = 0; i < IO_W; i++) begin : g_pad
            assign in_en[i]  = live;
            assign out_en[i] = live;
        end
    endgenerate

endmodule

// File: rtl/lp_sleep_seq.sv
// Top of the low-power sleep sequencer. Converts the entry and wake-up
// delays to cycle counts and wires the counter, state machine and pad
// enable decode. Assumes lp_req and pwr_good are already synchronous.
module lp_sleep_seq
    import lp_seq_pkg::*;
#(
    parameter int CLK_KHZ  = 200_000,
    parameter int ENTRY_NS = 800,
    parameter int EXIT_NS  = 200_000,
    parameter int IO_W     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lp_req,
    input  logic            pwr_good,
    output logic            core_en,
    output logic [IO_W-1:0] in_en,
    output logic [IO_W-1:0] out_en,
    output logic            reinit
);

    localparam int ENTRY_CYC = ns_to_cycles(longint'(CLK_KHZ), longint'(ENTRY_NS));
    localparam int EXIT_CYC  = ns_to_cycles(longint'(CLK_KHZ), longint'(EXIT_NS));
    localparam int MAX_CYC   = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    lp_state_e        state;
    logic             cnt_load;
    logic             cnt_dec;
    logic             cnt_zero;
    logic [CNT_W-1:0] cnt_val;

    lp_delay_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .cnt_zero (cnt_zero)
    );

    lp_seq_fsm #(
        .CNT_W      (CNT_W),
        .ENTRY_LOAD (ENTRY_CYC - 1),
        .EXIT_LOAD  (EXIT_CYC - 1)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lp_req   (lp_req),
        .pwr_good (pwr_good),
        .cnt_zero (cnt_zero),
        .state    (state),
        .cnt_load (cnt_load),
        .cnt_val  (cnt_val),
        .cnt_dec  (cnt_dec),
        .reinit   (reinit)
    );

    lp_io_ctrl #(.IO_W(IO_W)) u_io (
        .state   (state),
        .core_en (core_en),
        .in_en   (in_en),
        .out_en  (out_en)
    );

endmodule

// File: rtl/lp_sleep_seq_chk.sv
// Protocol checker for the sleep sequencer, bound to the top module.
// Counts consecutive sampled requests to check the entry window.
module lp_sleep_seq_chk #(
    parameter int ENTRY_CYC = 1,
    parameter int IO_W      = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lp_req,
    input logic            pwr_good,
    input logic            core_en,
    input logic [IO_W-1:0] in_en,
    input logic [IO_W-1:0] out_en,
    input logic            reinit
);

    int req_run;

    // Saturating count of consecutive edges with lp_req sampled high.
    always_ff @(posedge clk) begin
        if (!rst_n)       req_run <= 0;
        else if (!lp_req) req_run <= 0;
        else if (req_run <= ENTRY_CYC) req_run <= req_run + 1;
    end

    // R7: re-initialise lasts a single cycle.
    assert_reinit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> !reinit);

    // R7: re-initialise only while the core is live.
    assert_reinit_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |-> core_en);

    // R2 / R7: the core never comes back without a re-initialise request.
    assert_rise_reinit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_en) |-> reinit);

    // R9: power failure leaves everything off on the next cycle.
    assert_pwr_fail_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!core_en && (in_en == '0) && (out_en == '0) && !reinit));

    // R3: sleep is entered only after the request was held beyond the entry delay.
    assert_entry_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_en) && $past(pwr_good)) |-> (req_run > ENTRY_CYC));

    // R4: pads follow the core when the core is off.
    assert_pads_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |-> ((in_en == '0) && (out_en == '0)));

endmodule

bind lp_sleep_seq lp_sleep_seq_chk #(
    .ENTRY_CYC (ENTRY_CYC),
    .IO_W      (IO_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lp_req   (lp_req),
    .pwr_good (pwr_good),
    .core_en  (core_en),
    .in_en    (in_en),
    .out_en   (out_en),
    .reinit   (reinit)
);

// File: tb/sim_lp_sleep_seq.sv
// Bench for the sleep sequencer: directed timing cases, then random
// request patterns compared each cycle against a requirement model.
module sim_lp_sleep_seq;

    localparam int CLK_KHZ  = 200_000;
    localparam int ENTRY_NS = 800;
    localparam int EXIT_NS  = 2_000;
    localparam int IO_W     = 8;

    function automatic int cyc_of(input longint ns);
        longint c;
        c = (longint'(CLK_KHZ) * ns + 64'd999_999) / 64'd1_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    localparam int E = cyc_of(ENTRY_NS);
    localparam int X = cyc_of(EXIT_NS);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lp_req = 1'b0;
    logic            pwr_good = 1'b0;
    logic            core_en;
    logic [IO_W-1:0] in_en;
    logic [IO_W-1:0] out_en;
    logic            reinit;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    lp_sleep_seq #(
        .CLK_KHZ (CLK_KHZ), .ENTRY_NS (ENTRY_NS), .EXIT_NS (EXIT_NS), .IO_W (IO_W)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .lp_req (lp_req), .pwr_good (pwr_good),
        .core_en (core_en), .in_en (in_en), .out_en (out_en), .reinit (reinit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected pad word for a live or off device.
    function automatic logic [IO_W-1:0] pads(input bit live);
        return live ? {IO_W{1'b1}} : {IO_W{1'b0}};
    endfunction

    task automatic expect_live(input bit live, input string req);
        check(core_en == live, req, int'(core_en), int'(live));
        check((in_en == pads(live)) && (out_en == pads(live)), req,
              int'(out_en), int'(pads(live)));
    endtask

    // Requirement model: 0 off, 1 running, 2 entry pending, 3 asleep, 4 waking.
    int m_st = 0;
    int m_cnt = 0;
    bit m_rin = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0; m_rin <= 1'b0;
        end else if (!pwr_good) begin
            m_st <= 0; m_rin <= 1'b0;
        end else begin
            m_rin <= 1'b0;
            case (m_st)
                0: begin m_st <= 1; m_rin <= 1'b1; end
                1: if (lp_req) begin m_st <= 2; m_cnt <= E - 1; end
                2: if (!lp_req) m_st <= 1;
                   else if (m_cnt == 0) m_st <= 3;
                   else m_cnt <= m_cnt - 1;
                3: if (!lp_req) begin m_st <= 4; m_cnt <= X - 1; end
                4: if (lp_req) m_st <= 3;
                   else if (m_cnt == 0) begin m_st <= 1; m_rin <= 1'b1; end
                   else m_cnt <= m_cnt - 1;
                default: m_st <= 0;
            endcase
        end
    end

    // Per-cycle comparison during the random phase (R3..R10).
    always @(negedge clk) begin
        if (cmp_on) begin
            check(core_en == (m_st == 1 || m_st == 2), "R3/R6 model core_en",
                  int'(core_en), int'(m_st == 1 || m_st == 2));
            check(out_en == pads(m_st == 1 || m_st == 2), "R4 model out_en",
                  int'(out_en), int'(pads(m_st == 1 || m_st == 2)));
            check(reinit == m_rin, "R7 model reinit", int'(reinit), int'(m_rin));
        end
    end

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0 (run did not finish)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(3);
        expect_live(1'b0, "R1 reset");
        check(reinit == 1'b0, "R1 reset reinit", int'(reinit), 0);
        rst_n = 1'b1;
        step(3);
        expect_live(1'b0, "R9 supplies not good");

        // R2: power-up
        pwr_good = 1'b1;
        step(1);
        expect_live(1'b1, "R2 power-up live");
        check(reinit == 1'b1, "R2 power-up reinit", int'(reinit), 1);
        step(1);
        check(reinit == 1'b0, "R2 reinit ends", int'(reinit), 0);

        // R10: low request while live has no effect
        step(6);
        expect_live(1'b1, "R10 idle live");
        check(reinit == 1'b0, "R10 no reinit", int'(reinit), 0);

        // R5: aborted entry
        lp_req = 1'b1;
        step(E - 1);
        lp_req = 1'b0;
        step(3);
        expect_live(1'b1, "R5 abort stays live");
        check(reinit == 1'b0, "R5 abort no reinit", int'(reinit), 0);

        // R3/R4: full entry timing
        lp_req = 1'b1;
        step(E);
        expect_live(1'b1, "R3 live before delay");
        step(1);
        expect_live(1'b0, "R3/R4 asleep at delay");
        step(20);
        expect_live(1'b0, "R4 stays asleep");

        // R6/R7: wake-up timing and pulse
        lp_req = 1'b0;
        step(X);
        expect_live(1'b0, "R6 asleep before wake delay");
        step(1);
        expect_live(1'b1, "R6 live at wake delay");
        check(reinit == 1'b1, "R7 reinit on wake", int'(reinit), 1);
        step(1);
        check(reinit == 1'b0, "R7 reinit one cycle", int'(reinit), 0);

        // R8: request reasserted during wake-up
        lp_req = 1'b1;
        step(E + 1);
        expect_live(1'b0, "R8 asleep again");
        lp_req = 1'b0;
        step(X / 2);
        lp_req = 1'b1;
        step(X);
        expect_live(1'b0, "R8 wake abandoned");
        check(reinit == 1'b0, "R8 no reinit", int'(reinit), 0);
        lp_req = 1'b0;
        step(X);
        expect_live(1'b0, "R8 full delay reloaded");
        step(1);
        expect_live(1'b1, "R8 wake after full delay");

        // R9: power failure during entry
        step(2);
        lp_req = 1'b1;
        step(10);
        pwr_good = 1'b0;
        step(1);
        expect_live(1'b0, "R9 power fail off");
        check(reinit == 1'b0, "R9 no reinit", int'(reinit), 0);
        pwr_good = 1'b1;
        lp_req = 1'b0;
        step(1);
        expect_live(1'b1, "R2 power return live");
        check(reinit == 1'b1, "R2 power return reinit", int'(reinit), 1);

        // Random request patterns against the model
        void'($urandom(32'h5EED_1234));
        cmp_on = 1'b1;
        for (int it = 0; it < 60; it++) begin
            int mode;
            int len;
            mode = int'($urandom_range(0, 9));
            if (mode < 4)       len = int'($urandom_range(1, E + 4));
            else if (mode < 6)  len = E - 2 + int'($urandom_range(0, 4));
            else if (mode < 8)  len = int'($urandom_range(1, X + 8));
            else                len = X - 2 + int'($urandom_range(0, 4));
            lp_req = ~lp_req;
            if ($urandom_range(0, 15) == 0) begin
                pwr_good = 1'b0;
                step(int'($urandom_range(1, 4)));
                pwr_good = 1'b1;
            end
            step(len);
        end
        cmp_on = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule